// File: doc/BRIEF.md
# SPI DMA Handshake and Framing Controller

This block joins an SPI character shifter to a DMA engine. It holds one transmit byte and one receive byte. It raises a transmit request whenever the transmit holding register is empty and a receive request whenever a received byte is waiting. The DMA completes each request with its own acknowledge. Descriptor control bits written alongside a transmit byte drive the framing. A slave-select-valid flag opens the master's slave-select. An end-of-frame flag marks the byte after which slave-select is released. When that release happens, the block pulses end-of-frame back to the DMA.

A two-bit direction field selects the mode: disabled, receive only, transmit only, or full duplex. A single DMA channel can therefore serve a one-direction transfer. A master may only use the modes that transmit. A master set to receive only behaves as disabled. A slave that is not transmitting shifts out all-ones characters.

Four sticky error flags feed a single interrupt line. Each flag is cleared by writing 1 to it. The flags cover:
- transmit underrun
- collision (a write into a full register)
- abort (another device drives select while this block is master)
- receive overrun

Top module: `spi_dma_link`

## Requirements
- R1: When transmit is enabled and the transmit holding register is empty, dma_tx_req is high. In the cycle after dma_tx_ack is sampled, it is low. It stays low until sh_load takes the byte, and sh_load presents the acknowledged dma_tx_data byte on sh_tx_byte.
- R2: When receive is enabled, a sh_rx_valid strobe stores sh_rx_byte on dma_rx_data and raises dma_rx_req in the next cycle. dma_rx_req is low in the cycle after dma_rx_ack is sampled.
- R3: cfg_dir encodes the mode: bit 1 enables transmit and bit 0 enables receive. With cfg_dir = 00, both requests are held low, ss_out_n stays high, and descriptor writes have no effect.
- R4: With cfg_master = 1 and cfg_dir = 01, the block behaves as disabled: both requests are low, receive strobes are ignored, and ss_out_n stays high.
- R5: When transmit is not enabled, sh_tx_byte is all ones, dma_tx_req stays low, and sh_load never flags an underrun.
- R6: In master mode, an acknowledged write with dma_tx_ssv = 1 drives ss_out_n low in the next cycle. ss_out_n stays low while later bytes are written.
- R7: In master mode, a write with dma_tx_eof = 1 marks its byte as the last one. When sh_load takes that byte and the following sh_char_done arrives, the next cycle shows two things. First, ss_out_n is high. Second, there is a single-cycle pulse on dma_tx_done (if transmit is enabled) and on dma_rx_done (if receive is enabled).
- R8: In slave mode, a low-to-high transition of ss_in_n produces the same single-cycle done pulses, gated by direction in the same way.
- R9: Bit positions in err_status: bit 0 is transmit underrun, bit 1 is collision, bit 2 is abort and bit 3 is receive overrun. A bit sets one cycle after its event:
  - underrun: sh_load with an empty transmit register while a frame is active
  - collision: dma_tx_ack while the transmit register is full
  - abort: ss_in_n low while this block is an enabled master
  - overrun: sh_rx_valid while a byte is waiting and not being acknowledged
- R10: irq is high exactly when any err_status bit is set.
- R11: err_clr_we with err_clr_mask clears the masked bits and leaves the other bits unchanged. A new error event in the same cycle as its clear keeps the bit set.
- R12: When receive is not enabled, sh_rx_valid has no effect: dma_rx_req stays low and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dir | input | 2 | Direction mode: 00 off, 01 receive, 10 transmit, 11 both |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_tx_ack | input | 1 | Transmit acknowledge and write strobe |
| dma_tx_data | input | 8 | Transmit byte from the DMA |
| dma_tx_ssv | input | 1 | Descriptor slave-select-valid flag for this byte |
| dma_tx_eof | input | 1 | Descriptor end-of-frame strobe for this byte |
| dma_tx_done | output | 1 | Frame-ended pulse for the transmit channel |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_rx_ack | input | 1 | Receive acknowledge |
| dma_rx_data | output | 8 | Received byte |
| dma_rx_done | output | 1 | Frame-ended pulse for the receive channel |
| sh_load | input | 1 | Shifter takes the transmit byte |
| sh_tx_byte | output | 8 | Byte for the shifter |
| sh_char_done | input | 1 | Shifter finished a character |
| sh_rx_valid | input | 1 | Shifter delivers a received byte |
| sh_rx_byte | input | 8 | Received byte from the shifter |
| ss_in_n | input | 1 | Slave-select input (slave select, or fault sense in master mode) |
| ss_out_n | output | 1 | Master slave-select output |
| err_clr_we | input | 1 | Error clear strobe |
| err_clr_mask | input | 4 | Write-1-to-clear mask for err_status |
| err_status | output | 4 | Sticky error flags |
| irq | output | 1 | Error interrupt |

## Verification
The assertions assume that cfg_dir and cfg_master change only between frames. They also assume that the DMA acknowledges a request only after it has seen that request, except where a collision is being provoked on purpose. The bench keeps to this: it changes the mode only through a task that waits for idle cycles, and it issues every acknowledge from a task at the falling edge. Outside the abort test, ss_in_n is held high in master mode, so that a fault-sense low does not show up as an unplanned abort.

// File: rtl/spi_dma_pkg.sv
package spi_dma_pkg;

    typedef enum logic [1:0] {
        DIR_OFF  = 2'b00,
        DIR_RX   = 2'b01,
        DIR_TX   = 2'b10,
        DIR_BOTH = 2'b11
    } dir_e;

    localparam int ERR_COUNT = 4;
    localparam int ERR_UNDER = 0;
    localparam int ERR_COLL  = 1;
    localparam int ERR_ABORT = 2;
    localparam int ERR_OVR   = 3;

endpackage

// File: rtl/spi_dma_mode.sv
module spi_dma_mode
    import spi_dma_pkg::*;
(
    input  logic [1:0] cfg_dir,
    input  logic       cfg_master,
    output logic       mode_ok,
    output logic       tx_en,
    output logic       rx_en
);

    always_comb begin
        mode_ok = (cfg_dir != DIR_OFF) && !(cfg_master && (cfg_dir == DIR_RX));
        tx_en   = mode_ok && cfg_dir[1];
        rx_en   = mode_ok && cfg_dir[0];
    end

endmodule

// File: rtl/spi_dma_xfer.sv
module spi_dma_xfer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              tx_ack,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              sh_load,
    input  logic              sh_rx_valid,
    input  logic [DATA_W-1:0] sh_rx_byte,
    input  logic              rx_ack,
    output logic              tx_req,
    output logic              tx_full,
    output logic [DATA_W-1:0] sh_tx_byte,
    output logic              rx_req,
    output logic              rx_full,
    output logic [DATA_W-1:0] rx_data
);

    localparam logic [DATA_W-1:0] IDLE_CHAR = {DATA_W{1'b1}};

    typedef struct packed {
        logic              tx_full;
        logic              tx_req;
        logic [DATA_W-1:0] tx_byte;
        logic              rx_full;
        logic              rx_req;
        logic [DATA_W-1:0] rx_byte;
    } xfer_st_t;

    xfer_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;

        if (!tx_en) begin
            st_d.tx_full = 1'b0;
        end else if (tx_ack) begin
            st_d.tx_full = 1'b1;
            st_d.tx_byte = tx_data;
        end else if (sh_load) begin
            st_d.tx_full = 1'b0;
        end
        st_d.tx_req = tx_en && !st_d.tx_full;

        if (!rx_en) begin
            st_d.rx_full = 1'b0;
        end else if (sh_rx_valid) begin
            st_d.rx_full = 1'b1;
            st_d.rx_byte = sh_rx_byte;
        end else if (rx_ack) begin
            st_d.rx_full = 1'b0;
        end
        st_d.rx_req = rx_en && st_d.rx_full;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        tx_req     = st_q.tx_req;
        tx_full    = st_q.tx_full;
        sh_tx_byte = tx_en ? st_q.tx_byte : IDLE_CHAR;
        rx_req     = st_q.rx_req;
        rx_full    = st_q.rx_full;
        rx_data    = st_q.rx_byte;
    end

endmodule

// File: rtl/spi_dma_frame.sv
module spi_dma_frame (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_ok,
    input  logic tx_en,
    input  logic rx_en,
    input  logic cfg_master,
    input  logic tx_ack,
    input  logic tx_ssv,
    input  logic tx_eof,
    input  logic tx_full,
    input  logic sh_load,
    input  logic sh_char_done,
    input  logic ss_in_n,
    output logic ss_out_n,
    output logic frame_active,
    output logic tx_done,
    output logic rx_done
);

    typedef struct packed {
        logic ssv;
        logic teof;
        logic last;
        logic ss_n;
        logic ss_prev;
        logic tx_done;
        logic rx_done;
    } frame_st_t;

    localparam frame_st_t FRAME_RST = '{
        ssv: 1'b0, teof: 1'b0, last: 1'b0, ss_n: 1'b1,
        ss_prev: 1'b1, tx_done: 1'b0, rx_done: 1'b0
    };

    frame_st_t st_d, st_q;
    logic      end_evt;

    always_comb begin
        st_d         = st_q;
        st_d.tx_done = 1'b0;
        st_d.rx_done = 1'b0;
        end_evt      = 1'b0;

        if (!mode_ok || !cfg_master) begin
            st_d.ssv  = 1'b0;
            st_d.teof = 1'b0;
            st_d.last = 1'b0;
        end else begin
            // closing the frame after the marked byte has shifted
            if (sh_char_done && st_q.last) begin
                st_d.ssv  = 1'b0;
                st_d.teof = 1'b0;
                st_d.last = 1'b0;
                end_evt   = 1'b1;
            end
            // the marked byte leaves the holding register
            if (sh_load && st_q.teof && tx_full) begin
                st_d.last = 1'b1;
            end
            // descriptor flags ride along with the DMA write
            if (tx_ack && tx_en) begin
                if (tx_ssv) st_d.ssv  = 1'b1;
                if (tx_eof) st_d.teof = 1'b1;
            end
        end

        if (mode_ok && !cfg_master && ss_in_n && !st_q.ss_prev) begin
            end_evt = 1'b1;
        end

        st_d.ss_prev = ss_in_n;
        st_d.tx_done = end_evt && tx_en;
        st_d.rx_done = end_evt && rx_en;
        st_d.ss_n    = !(cfg_master && mode_ok && st_d.ssv);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= FRAME_RST;
        else        st_q <= st_d;
    end

    always_comb begin
        ss_out_n     = st_q.ss_n;
        frame_active = cfg_master ? st_q.ssv : !ss_in_n;
        tx_done      = st_q.tx_done;
        rx_done      = st_q.rx_done;
    end

endmodule

// File: rtl/spi_dma_err.sv
module spi_dma_err
    import spi_dma_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_ok,
    input  logic                 tx_en,
    input  logic                 rx_en,
    input  logic                 cfg_master,
    input  logic                 sh_load,
    input  logic                 tx_full,
    input  logic                 frame_active,
    input  logic                 tx_ack,
    input  logic                 sh_rx_valid,
    input  logic                 rx_full,
    input  logic                 rx_ack,
    input  logic                 ss_in_n,
    input  logic                 clr_we,
    input  logic [ERR_COUNT-1:0] clr_mask,
    output logic [ERR_COUNT-1:0] err_status,
    output logic                 irq
);

    typedef struct packed {
        logic [ERR_COUNT-1:0] err;
        logic                 irq;
    } err_st_t;

    err_st_t              st_d, st_q;
    logic [ERR_COUNT-1:0] set_vec;
    logic [ERR_COUNT-1:0] clr_vec;

    always_comb begin
        set_vec            = '0;
        set_vec[ERR_UNDER] = tx_en && sh_load && !tx_full && frame_active;
        set_vec[ERR_COLL]  = tx_en && tx_ack && tx_full && !sh_load;
        set_vec[ERR_ABORT] = mode_ok && cfg_master && !ss_in_n;
        set_vec[ERR_OVR]   = rx_en && sh_rx_valid && rx_full && !rx_ack;
        clr_vec            = clr_we ? clr_mask : '0;
    end

    for (genvar b = 0; b < ERR_COUNT; b++) begin : g_bit
        always_comb begin
            st_d.err[b] = (st_q.err[b] && !clr_vec[b]) || set_vec[b];
        end
    end

    always_comb st_d.irq = |st_d.err;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        err_status = st_q.err;
        irq        = st_q.irq;
    end

endmodule

// File: rtl/spi_dma_link.sv
module spi_dma_link
    import spi_dma_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           cfg_dir,
    input  logic                 cfg_master,
    output logic                 dma_tx_req,
    input  logic                 dma_tx_ack,
    input  logic [DATA_W-1:0]    dma_tx_data,
    input  logic                 dma_tx_ssv,
    input  logic                 dma_tx_eof,
    output logic                 dma_tx_done,
    output logic                 dma_rx_req,
    input  logic                 dma_rx_ack,
    output logic [DATA_W-1:0]    dma_rx_data,
    output logic                 dma_rx_done,
    input  logic                 sh_load,
    output logic [DATA_W-1:0]    sh_tx_byte,
    input  logic                 sh_char_done,
    input  logic                 sh_rx_valid,
    input  logic [DATA_W-1:0]    sh_rx_byte,
    input  logic                 ss_in_n,
    output logic                 ss_out_n,
    input  logic                 err_clr_we,
    input  logic [ERR_COUNT-1:0] err_clr_mask,
    output logic [ERR_COUNT-1:0] err_status,
    output logic                 irq
);

    logic mode_ok, tx_en, rx_en;
    logic tx_full, rx_full, frame_active;

    spi_dma_mode u_mode (
        .cfg_dir    (cfg_dir),
        .cfg_master (cfg_master),
        .mode_ok    (mode_ok),
        .tx_en      (tx_en),
        .rx_en      (rx_en)
    );

    spi_dma_xfer #(.DATA_W(DATA_W)) u_xfer (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en       (tx_en),
        .rx_en       (rx_en),
        .tx_ack      (dma_tx_ack),
        .tx_data     (dma_tx_data),
        .sh_load     (sh_load),
        .sh_rx_valid (sh_rx_valid),
        .sh_rx_byte  (sh_rx_byte),
        .rx_ack      (dma_rx_ack),
        .tx_req      (dma_tx_req),
        .tx_full     (tx_full),
        .sh_tx_byte  (sh_tx_byte),
        .rx_req      (dma_rx_req),
        .rx_full     (rx_full),
        .rx_data     (dma_rx_data)
    );

    spi_dma_frame u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_ok      (mode_ok),
        .tx_en        (tx_en),
        .rx_en        (rx_en),
        .cfg_master   (cfg_master),
        .tx_ack       (dma_tx_ack),
        .tx_ssv       (dma_tx_ssv),
        .tx_eof       (dma_tx_eof),
        .tx_full      (tx_full),
        .sh_load      (sh_load),
        .sh_char_done (sh_char_done),
        .ss_in_n      (ss_in_n),
        .ss_out_n     (ss_out_n),
        .frame_active (frame_active),
        .tx_done      (dma_tx_done),
        .rx_done      (dma_rx_done)
    );

    spi_dma_err u_err (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_ok      (mode_ok),
        .tx_en        (tx_en),
        .rx_en        (rx_en),
        .cfg_master   (cfg_master),
        .sh_load      (sh_load),
        .tx_full      (tx_full),
        .frame_active (frame_active),
        .tx_ack       (dma_tx_ack),
        .sh_rx_valid  (sh_rx_valid),
        .rx_full      (rx_full),
        .rx_ack       (dma_rx_ack),
        .ss_in_n      (ss_in_n),
        .clr_we       (err_clr_we),
        .clr_mask     (err_clr_mask),
        .err_status   (err_status),
        .irq          (irq)
    );

endmodule

// File: rtl/spi_dma_link_chk.sv
module spi_dma_link_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_dir,
    input logic       cfg_master,
    input logic       dma_tx_req,
    input logic       dma_tx_ack,
    input logic       dma_tx_ssv,
    input logic       dma_tx_done,
    input logic       dma_rx_req,
    input logic       dma_rx_ack,
    input logic       sh_rx_valid,
    input logic       sh_load,
    input logic       ss_out_n,
    input logic       err_clr_we,
    input logic [3:0] err_clr_mask,
    input logic [3:0] err_status
);

    // R1
    tx_req_drops_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_tx_ack |=> !dma_tx_req);

    // R2
    rx_req_drops_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rx_ack && !sh_rx_valid) |=> !dma_rx_req);

    // R3
    off_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dir == 2'b00) |=> (ss_out_n && !dma_rx_req && !dma_tx_req));

    // R5
    no_tx_req_without_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_dir[1] |=> !dma_tx_req);

    // R6
    ssv_opens_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && cfg_dir == 2'b10 && dma_tx_ack && dma_tx_ssv) |=> !ss_out_n);

    // R7
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_tx_done |=> !dma_tx_done);

    // R11
    clear_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr_we && err_clr_mask[0] && !sh_load) |=> !err_status[0]);

    // R12
    no_rx_req_without_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_dir[0] |=> !dma_rx_req);

endmodule

bind spi_dma_link spi_dma_link_chk u_chk (.*);

// File: tb/sim_spi_dma_link.sv
module sim_spi_dma_link;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_dir = 2'b10;
    logic       cfg_master = 1'b1;
    logic       dma_tx_req, dma_tx_done, dma_rx_req, dma_rx_done;
    logic       dma_tx_ack = 1'b0, dma_tx_ssv = 1'b0, dma_tx_eof = 1'b0;
    logic [7:0] dma_tx_data = 8'h00;
    logic       dma_rx_ack = 1'b0;
    logic [7:0] dma_rx_data, sh_tx_byte;
    logic       sh_load = 1'b0, sh_char_done = 1'b0, sh_rx_valid = 1'b0;
    logic [7:0] sh_rx_byte = 8'h00;
    logic       ss_in_n = 1'b1;
    logic       ss_out_n;
    logic       err_clr_we = 1'b0;
    logic [3:0] err_clr_mask = 4'h0;
    logic [3:0] err_status;
    logic       irq;

    int  n_chk = 0;
    int  n_fail = 0;
    int  cyc = 0;
    bit  auto_rx = 1'b0;
    bit  finished = 1'b0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];

    always #10 clk = ~clk;

    spi_dma_link u0 (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cyc);
            finish_run();
        end
    end

    // monitor: sole driver of dma_rx_ack, compares received bytes with the scoreboard
    always @(negedge clk) begin
        if (dma_rx_ack) begin
            dma_rx_ack = 1'b0;
        end else if (auto_rx && dma_rx_req) begin
            if (rxq.size() == 0) begin
                chk("R2 unexpected rx byte", 32'(dma_rx_data), 32'hFFFF_FFFF);
            end else begin
                chk("R2 scoreboard rx byte", 32'(dma_rx_data), 32'(rxq.pop_front()));
            end
            dma_rx_ack = 1'b1;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] dir, input logic mst);
        @(negedge clk);
        cfg_dir = dir;
        cfg_master = mst;
        idle(2);
    endtask

    task automatic dma_write(input logic [7:0] data, input bit ssv, input bit eof, input bit push);
        @(negedge clk);
        dma_tx_ack = 1'b1;
        dma_tx_data = data;
        dma_tx_ssv = ssv;
        dma_tx_eof = eof;
        if (push) txq.push_back(data);
        @(negedge clk);
        dma_tx_ack = 1'b0;
        dma_tx_ssv = 1'b0;
        dma_tx_eof = 1'b0;
    endtask

    task automatic shift_load(input bit cmp);
        if (cmp) chk("R1 scoreboard tx byte", 32'(sh_tx_byte), 32'(txq.pop_front()));
        @(negedge clk);
        sh_load = 1'b1;
        @(negedge clk);
        sh_load = 1'b0;
    endtask

    task automatic shift_done();
        @(negedge clk);
        sh_char_done = 1'b1;
        @(negedge clk);
        sh_char_done = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] data);
        @(negedge clk);
        sh_rx_valid = 1'b1;
        sh_rx_byte = data;
        rxq.push_back(data);
        @(negedge clk);
        sh_rx_valid = 1'b0;
    endtask

    task automatic err_clear(input logic [3:0] mask);
        @(negedge clk);
        err_clr_we = 1'b1;
        err_clr_mask = mask;
        @(negedge clk);
        err_clr_we = 1'b0;
        err_clr_mask = 4'h0;
    endtask

    initial begin
        idle(3);
        chk("R1 reset tx req", 32'(dma_tx_req), 0);
        chk("R6 reset ss_out_n", 32'(ss_out_n), 1);
        chk("R9 reset err", 32'(err_status), 0);
        chk("R10 reset irq", 32'(irq), 0);
        chk("R7 reset tx done", 32'(dma_tx_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 tx req when empty", 32'(dma_tx_req), 1);

        // master transmit-only two-byte frame
        dma_write(8'hA1, 1, 0, 1);
        chk("R1 tx req after ack", 32'(dma_tx_req), 0);
        chk("R6 ss_out_n opened", 32'(ss_out_n), 0);
        idle(2);
        chk("R1 tx req held until load", 32'(dma_tx_req), 0);
        shift_load(1);
        chk("R1 tx req after load", 32'(dma_tx_req), 1);
        dma_write(8'hB2, 0, 1, 1);
        shift_done();
        chk("R6 ss_out_n held mid frame", 32'(ss_out_n), 0);
        chk("R7 no early done", 32'(dma_tx_done), 0);
        shift_load(1);
        shift_done();
        chk("R7 ss_out_n released", 32'(ss_out_n), 1);
        chk("R7 tx done pulse", 32'(dma_tx_done), 1);
        chk("R7 rx done gated off", 32'(dma_rx_done), 0);
        @(negedge clk);
        chk("R7 tx done one cycle", 32'(dma_tx_done), 0);

        // underrun inside a frame
        dma_write(8'hC3, 1, 0, 1);
        shift_load(1);
        shift_load(0);
        chk("R9 underrun bit0", 32'(err_status), 32'h1);
        chk("R10 irq on error", 32'(irq), 1);
        err_clear(4'b0010);
        chk("R11 clear other bit keeps bit0", 32'(err_status), 32'h1);
        // clear and new underrun in the same cycle: set wins
        @(negedge clk);
        err_clr_we = 1'b1;
        err_clr_mask = 4'b0001;
        sh_load = 1'b1;
        @(negedge clk);
        err_clr_we = 1'b0;
        err_clr_mask = 4'h0;
        sh_load = 1'b0;
        chk("R11 set wins over clear", 32'(err_status), 32'h1);
        err_clear(4'b0001);
        chk("R11 bit0 cleared", 32'(err_status), 32'h0);
        chk("R10 irq cleared", 32'(irq), 0);

        // collision: second write into a full register
        dma_write(8'hD4, 0, 0, 1);
        dma_write(8'hE5, 0, 0, 0);
        chk("R9 collision bit1", 32'(err_status), 32'h2);
        txq.delete();
        txq.push_back(8'hE5);
        shift_load(1);
        dma_write(8'h96, 0, 1, 1);
        shift_load(1);
        shift_done();
        chk("R7 second frame closed", 32'(ss_out_n), 1);
        err_clear(4'b0010);
        chk("R11 collision cleared", 32'(err_status), 32'h0);

        // abort: select sensed low while master
        @(negedge clk);
        ss_in_n = 1'b0;
        @(negedge clk);
        ss_in_n = 1'b1;
        chk("R9 abort bit2", 32'(err_status), 32'h4);
        err_clear(4'b0100);

        // receive ignored in transmit-only mode
        rx_push(8'h77);
        rx_push(8'h78);
        chk("R12 rx req stays low", 32'(dma_rx_req), 0);
        chk("R12 no overrun", 32'(err_status), 32'h0);
        rxq.delete();

        // full duplex master: receive path and overrun
        set_mode(2'b11, 1'b1);
        rx_push(8'h11);
        chk("R2 rx req raised", 32'(dma_rx_req), 1);
        chk("R2 rx data", 32'(dma_rx_data), 32'h11);
        rx_push(8'h22);
        chk("R9 overrun bit3", 32'(err_status), 32'h8);
        chk("R2 rx data replaced", 32'(dma_rx_data), 32'h22);
        rxq.delete();
        rxq.push_back(8'h22);
        auto_rx = 1'b1;
        idle(3);
        chk("R2 rx req after ack", 32'(dma_rx_req), 0);
        chk("R2 scoreboard drained", 32'(rxq.size()), 0);
        rx_push(8'h5A);
        idle(3);
        chk("R2 second byte drained", 32'(rxq.size()), 0);
        err_clear(4'b1000);
        dma_write(8'h3C, 1, 1, 1);
        shift_load(1);
        shift_done();
        chk("R7 duplex tx done", 32'(dma_tx_done), 1);
        chk("R7 duplex rx done", 32'(dma_rx_done), 1);
        chk("R7 duplex ss released", 32'(ss_out_n), 1);

        // master with receive-only: treated as off
        auto_rx = 1'b0;
        set_mode(2'b01, 1'b1);
        chk("R4 tx req low", 32'(dma_tx_req), 0);
        dma_write(8'h44, 1, 0, 0);
        chk("R4 ss stays high", 32'(ss_out_n), 1);
        rx_push(8'h45);
        chk("R4 rx ignored", 32'(dma_rx_req), 0);
        rxq.delete();

        // disabled
        set_mode(2'b00, 1'b1);
        dma_write(8'h55, 1, 0, 0);
        chk("R3 off ss high", 32'(ss_out_n), 1);
        chk("R3 off tx req low", 32'(dma_tx_req), 0);
        rx_push(8'h56);
        chk("R3 off rx req low", 32'(dma_rx_req), 0);
        rxq.delete();

        // slave receive-only
        set_mode(2'b01, 1'b0);
        chk("R5 tx req low", 32'(dma_tx_req), 0);
        chk("R5 all-ones byte", 32'(sh_tx_byte), 32'hFF);
        @(negedge clk);
        ss_in_n = 1'b0;
        shift_load(0);
        chk("R5 no underrun", 32'(err_status), 32'h0);
        @(negedge clk);
        ss_in_n = 1'b1;
        @(negedge clk);
        chk("R8 slave rx done", 32'(dma_rx_done), 1);
        chk("R8 slave tx done gated", 32'(dma_tx_done), 0);
        @(negedge clk);
        chk("R8 done one cycle", 32'(dma_rx_done), 0);

        idle(2);
        finish_run();
    end

endmodule